// File: doc/BRIEF.md
# Audio Zero-Run Detector

This block watches six parallel audio sample words, one set per frame, and drives two zero-detect flags. Each flag is tied to a group of channels. A flag rises once every channel in its group has carried an all-zero word for a long run of consecutive frames, 8192 by default. Any nonzero word on a channel in the group ends the run. The flags can be used to mute or power down analog output stages that would otherwise amplify idle noise.

Three control inputs override the counting. In parallel control mode both flags stay low. In serial mode, a cleared core-run bit or an active DAC power-down forces both flags high. The enable input selects all six channels for both flags. When the enable is low, a 4-bit grouping code picks how channels are split between the two flags.

Top module: `zero_run_detect`

## Requirements
- R1: While `rst` is high at a clock edge, both flags are 0 after that edge.
- R2: With channels selected and no override, a flag becomes 1 at the clock edge of the strobed frame that completes `RUN_LEN` (default 8192) consecutive frames in which every selected channel word is zero. After the frame before that one, the flag is still 0.
- R3: A strobed frame with any nonzero word on a channel selected for a flag makes that flag 0 at that edge and restarts its run from zero.
- R4: While zero frames continue beyond `RUN_LEN`, the run count saturates, does not wrap, and the flag stays 1.
- R5: `par_mode` = 1 makes both flags 0 after the next edge and clears both runs. This override ranks above every other input.
- R6: With `par_mode` = 0, `core_run` = 0 or `dac_pd` = 1 makes both flags 1 after the next edge and clears both runs. The first strobed zero frame after release therefore drops the flags.
- R7: `det_en` = 1 selects all six channels for both flags, whatever the value of `grp_mode`.
- R8: With `det_en` = 0, `grp_mode` selects the channel groups. Channel c is bits [24c+23:24c] of `samples`. The codes are:
  - 0: both flags use all six channels.
  - 1: flag A uses {0,1} and flag B uses {2,3,4,5}.
  - 2: flag A uses {0,1,2,3} and flag B uses {4,5}.
  - 3: flag A uses the even channels and flag B uses the odd channels.
  - Any other code selects no channel and holds both flags at 0.
- R9: A nonzero word on a channel not selected for a flag has no effect on that flag.
- R10: Sample values on cycles with `frame_stb` = 0 have no effect. Outside an override, the flags change only at strobed edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe that marks a valid frame of samples |
| samples | input | NCH*SW (144) | Six 24-bit sample words, channel c at [24c+23:24c] |
| par_mode | input | 1 | Parallel control mode; forces both flags low |
| core_run | input | 1 | Core run bit; 0 forces both flags high |
| dac_pd | input | 1 | DAC power-down; 1 forces both flags high |
| det_en | input | 1 | Detection enable; 1 selects all channels for both flags |
| grp_mode | input | MODE_W (4) | Channel grouping code used when det_en is 0 |
| flag_a | output | 1 | Zero-run flag A |
| flag_b | output | 1 | Zero-run flag B |

## Verification
A run count that is corrupt or wraps would appear at the ports as a flag that rises early, late, or falls during a long zero run. The saturation check runs 1000 frames past the limit to catch this. A wrong group mask shows up when a flag either follows a channel it should ignore or misses one it should watch. Because each flag is a register updated on the strobe edge, a fault is visible one cycle after the frame that triggers it. This is why the reference model is compared with the flags on every clock.

// File: rtl/zd_pkg.sv
package zd_pkg;

  // Number of flags the block drives.
  localparam int NFLAG = 2;

  // Grouping codes used when the enable input is low.
  typedef enum logic [3:0] {
    GM_ALL        = 4'd0,
    GM_PAIR_REST  = 4'd1,
    GM_QUAD_PAIR  = 4'd2,
    GM_EVEN_ODD   = 4'd3,
    GM_OFF        = 4'd7
  } grp_mode_e;

  // Index of each flag within the flag vector.
  localparam int FLAG_A = 0;
  localparam int FLAG_B = 1;

endpackage

// File: rtl/zd_zero_vec.sv
module zd_zero_vec #(
  parameter int NCH = 6,
  parameter int SW  = 24
) (
  input  logic [NCH*SW-1:0] samples,
  output logic [NCH-1:0]    is_zero
);

  // One comparator per channel word.
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign is_zero[g] = (samples[g*SW +: SW] == '0);
  end

endmodule

// File: rtl/zd_group_map.sv
module zd_group_map #(
  parameter int NCH    = 6,
  parameter int MODE_W = 4
) (
  input  logic              det_en,
  input  logic [MODE_W-1:0] grp_mode,
  output logic [NCH-1:0]    mask_a,
  output logic [NCH-1:0]    mask_b
);
  import zd_pkg::*;

  localparam logic [MODE_W-1:0] C_ALL  = MODE_W'(GM_ALL);
  localparam logic [MODE_W-1:0] C_PAIR = MODE_W'(GM_PAIR_REST);
  localparam logic [MODE_W-1:0] C_QUAD = MODE_W'(GM_QUAD_PAIR);
  localparam logic [MODE_W-1:0] C_EO   = MODE_W'(GM_EVEN_ODD);

  logic [MODE_W-1:0] eff_mode;

  // The enable input overrides the code with the all-channel grouping.
  assign eff_mode = det_en ? C_ALL : grp_mode;

  always_comb begin
    mask_a = '0;
    mask_b = '0;
    for (int i = 0; i < NCH; i++) begin
      case (eff_mode)
        C_ALL: begin
          mask_a[i] = 1'b1;
          mask_b[i] = 1'b1;
        end
        C_PAIR: begin
          mask_a[i] = (i < 2);
          mask_b[i] = (i >= 2);
        end
        C_QUAD: begin
          mask_a[i] = (i < 4);
          mask_b[i] = (i >= 4);
        end
        C_EO: begin
          mask_a[i] = ((i % 2) == 0);
          mask_b[i] = ((i % 2) == 1);
        end
        default: begin
          mask_a[i] = 1'b0;
          mask_b[i] = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/zd_run_counter.sv
module zd_run_counter #(
  parameter int RUN_LEN = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_low,    // parallel-mode override
  input  logic force_high,  // core stopped or DAC powered down
  input  logic armed,       // at least one channel selected
  input  logic stb,         // frame strobe
  input  logic quiet,       // every selected channel is zero
  output logic flag
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  // Saturating increment: holds at the limit instead of wrapping.
  assign cnt_inc = (cnt_q == LIMIT) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else if (hold_low) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else if (force_high) begin
      cnt_q <= '0;
      flag  <= 1'b1;
    end else if (!armed) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else if (stb) begin
      if (quiet) begin
        cnt_q <= cnt_inc;
        flag  <= (cnt_inc == LIMIT);
      end else begin
        cnt_q <= '0;
        flag  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/zero_run_detect.sv
module zero_run_detect #(
  parameter int NCH     = 6,
  parameter int SW      = 24,
  parameter int MODE_W  = 4,
  parameter int RUN_LEN = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic [NCH*SW-1:0] samples,
  input  logic              par_mode,
  input  logic              core_run,
  input  logic              dac_pd,
  input  logic              det_en,
  input  logic [MODE_W-1:0] grp_mode,
  output logic              flag_a,
  output logic              flag_b
);
  import zd_pkg::*;

  logic [NCH-1:0]            is_zero;
  logic [NFLAG-1:0][NCH-1:0] masks;
  logic [NFLAG-1:0]          flags;
  logic                      forced;

  assign forced = !core_run || dac_pd;

  zd_zero_vec #(.NCH(NCH), .SW(SW)) u_zero (
    .samples (samples),
    .is_zero (is_zero)
  );

  zd_group_map #(.NCH(NCH), .MODE_W(MODE_W)) u_map (
    .det_en   (det_en),
    .grp_mode (grp_mode),
    .mask_a   (masks[FLAG_A]),
    .mask_b   (masks[FLAG_B])
  );

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    logic quiet;
    logic armed;

    // A run continues only if no selected channel carries data.
    assign quiet = &(is_zero | ~masks[f]);
    assign armed = |masks[f];

    zd_run_counter #(.RUN_LEN(RUN_LEN)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .hold_low   (par_mode),
      .force_high (forced),
      .armed      (armed),
      .stb        (frame_stb),
      .quiet      (quiet),
      .flag       (flags[f])
    );
  end

  assign flag_a = flags[FLAG_A];
  assign flag_b = flags[FLAG_B];

endmodule

// File: rtl/zd_checker.sv
module zd_checker #(
  parameter int NCH = 6,
  parameter int SW  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_stb,
  input logic [NCH*SW-1:0] samples,
  input logic              par_mode,
  input logic              core_run,
  input logic              dac_pd,
  input logic              det_en,
  input logic              flag_a,
  input logic              flag_b
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!flag_a && !flag_b)); // R1

  AST_PAR_LOW: assert property (@(posedge clk) disable iff (rst)
    par_mode |=> (!flag_a && !flag_b)); // R5

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!par_mode && (!core_run || dac_pd)) |=> (flag_a && flag_b)); // R6

  AST_DATA_DROPS: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && det_en && !par_mode && core_run && !dac_pd && (samples != '0))
      |=> (!flag_a && !flag_b)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!frame_stb && det_en && !par_mode && core_run && !dac_pd)
      |=> ($stable(flag_a) && $stable(flag_b))); // R10

endmodule

bind zero_run_detect zd_checker #(.NCH(NCH), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_stb (frame_stb),
  .samples   (samples),
  .par_mode  (par_mode),
  .core_run  (core_run),
  .dac_pd    (dac_pd),
  .det_en    (det_en),
  .flag_a    (flag_a),
  .flag_b    (flag_b)
);

// File: tb/tb_zero_run_detect.sv
module tb_zero_run_detect;
  localparam int NCH = 6;
  localparam int SW  = 24;
  localparam int RUN = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0;
  logic [NCH*SW-1:0] samples = '0;
  logic par_mode = 1'b0;
  logic core_run = 1'b1;
  logic dac_pd = 1'b0;
  logic det_en = 1'b1;
  logic [3:0] grp_mode = 4'd4;
  logic flag_a, flag_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int  mcnt [2];
  logic mflag [2];

  always #10 clk = ~clk;

  zero_run_detect dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .samples(samples),
    .par_mode(par_mode), .core_run(core_run), .dac_pd(dac_pd),
    .det_en(det_en), .grp_mode(grp_mode), .flag_a(flag_a), .flag_b(flag_b)
  );

  function automatic logic [5:0] sel(input int f, input logic en, input logic [3:0] m);
    logic [3:0] c;
    c = en ? 4'd0 : m;
    case (c)
      4'd0: return 6'b111111;
      4'd1: return (f == 0) ? 6'b000011 : 6'b111100;
      4'd2: return (f == 0) ? 6'b001111 : 6'b110000;
      4'd3: return (f == 0) ? 6'b010101 : 6'b101010;
      default: return 6'b000000;
    endcase
  endfunction

  // Channels with a 1 in zmask carry zero, the others a nonzero word.
  function automatic logic [NCH*SW-1:0] pat(input logic [5:0] zmask);
    logic [NCH*SW-1:0] v;
    for (int c = 0; c < NCH; c++)
      v[c*SW +: SW] = zmask[c] ? 24'h0 : 24'(c + 1) << (c * 3);
    return v;
  endfunction

  // Behavioural reference model.
  always @(posedge clk) begin
    for (int f = 0; f < 2; f++) begin
      logic [5:0] m;
      bit q;
      m = sel(f, det_en, grp_mode);
      q = 1;
      for (int c = 0; c < NCH; c++)
        if (m[c] && samples[c*SW +: SW] != 0) q = 0;
      if (rst || par_mode) begin
        mcnt[f] = 0; mflag[f] = 0;
      end else if (!core_run || dac_pd) begin
        mcnt[f] = 0; mflag[f] = 1;
      end else if (m == 0) begin
        mcnt[f] = 0; mflag[f] = 0;
      end else if (frame_stb) begin
        if (q) begin
          if (mcnt[f] < RUN) mcnt[f]++;
          mflag[f] = (mcnt[f] == RUN);
        end else begin
          mcnt[f] = 0; mflag[f] = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (flag_a !== mflag[0] || flag_b !== mflag[1]) begin
        errors++;
        $display("FAIL model(R2 R3 R8) t=%0t act=%b%b exp=%b%b",
                 $time, flag_a, flag_b, mflag[0], mflag[1]);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic frames(input logic [NCH*SW-1:0] d, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); frame_stb = 1'b1; samples = d;
      @(negedge clk); frame_stb = 1'b0; samples = {NCH{24'hA5A5A5}};
    end
  endtask

  initial begin
    mcnt[0] = 0; mcnt[1] = 0; mflag[0] = 0; mflag[1] = 0;
    repeat (3) @(negedge clk);
    chk("R1 flag_a in reset", flag_a, 1'b0);
    chk("R1 flag_b in reset", flag_b, 1'b0);
    rst = 1'b0;

    // det_en high with a disabled code: all six channels still watched.
    frames(pat(6'b111111), RUN - 1);
    chk("R2 flag_a one frame short", flag_a, 1'b0);
    frames(pat(6'b111111), 1);
    chk("R2 R10 R7 flag_a at run end", flag_a, 1'b1);
    chk("R7 flag_b at run end", flag_b, 1'b1);
    frames(pat(6'b111111), 1000);
    chk("R4 flag_a saturated", flag_a, 1'b1);
    chk("R4 flag_b saturated", flag_b, 1'b1);

    frames(pat(6'b110111), 1);
    chk("R3 flag_a drops on data", flag_a, 1'b0);
    chk("R3 flag_b drops on data", flag_b, 1'b0);

    @(negedge clk); dac_pd = 1'b1;
    @(negedge clk);
    chk("R6 power-down forces flag_a", flag_a, 1'b1);
    chk("R6 power-down forces flag_b", flag_b, 1'b1);
    dac_pd = 1'b0; core_run = 1'b0;
    @(negedge clk);
    chk("R6 core stop forces flag_a", flag_a, 1'b1);
    core_run = 1'b1;
    frames(pat(6'b111111), 1);
    chk("R6 run restarts after release", flag_a, 1'b0);

    frames(pat(6'b111111), RUN - 2);
    chk("R3 restarted run short", flag_a, 1'b0);
    frames(pat(6'b111111), 1);
    chk("R3 restarted run complete", flag_a, 1'b1);

    // Mode 1: channels 0,1 zero, rest busy.
    frames(pat(6'b000000), 1);
    det_en = 1'b0; grp_mode = 4'd1;
    frames(pat(6'b000011), RUN);
    chk("R8 R9 mode1 flag_a", flag_a, 1'b1);
    chk("R8 mode1 flag_b", flag_b, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); samples = pat(6'b000000);
    end
    chk("R10 unstrobed data ignored", flag_a, 1'b1);

    // Mode 2: channels 4,5 zero.
    frames(pat(6'b000000), 1);
    grp_mode = 4'd2;
    frames(pat(6'b110000), RUN);
    chk("R8 mode2 flag_a", flag_a, 1'b0);
    chk("R8 R9 mode2 flag_b", flag_b, 1'b1);

    // Mode 3: odd channels zero.
    frames(pat(6'b000000), 1);
    grp_mode = 4'd3;
    frames(pat(6'b101010), RUN);
    chk("R8 mode3 flag_a", flag_a, 1'b0);
    chk("R8 R9 mode3 flag_b", flag_b, 1'b1);

    grp_mode = 4'd9;
    frames(pat(6'b111111), 5);
    chk("R8 unused code flag_a", flag_a, 1'b0);
    chk("R8 unused code flag_b", flag_b, 1'b0);

    @(negedge clk); dac_pd = 1'b1;
    @(negedge clk); par_mode = 1'b1;
    @(negedge clk);
    chk("R5 parallel mode over power-down a", flag_a, 1'b0);
    chk("R5 parallel mode over power-down b", flag_b, 1'b0);
    par_mode = 1'b0;
    @(negedge clk);
    chk("R6 forced again after parallel mode", flag_b, 1'b1);
    dac_pd = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule